// File: doc/BRIEF.md
# Dual-Standard FSK Tone Modulator

This block produces the phase word of a frequency-shift-keyed carrier for 300 bit/s links. One clock cycle is one output sample. While transmission is enabled, a numerically controlled oscillator adds a per-sample tuning word to a 32-bit phase accumulator. The tuning word is one of eight, chosen by three inputs: the signalling standard (Bell 103 or V.21), the station role (calling or answering) and the data bit. A sine lookup downstream turns the phase word into a waveform.

The data bit and both selects are sampled only on an internal bit-rate strobe. The tone therefore stays fixed for a whole bit. A tone change only swaps the tuning word and never touches the accumulator, so the phase trace has no jumps. While the block transmits, it raises a flag that tells the surrounding data path to route bits past its rate converter and scrambler, because FSK operation never uses either.

Top module: `fsk_tone_mod`

## Requirements
- R1: While reset is asserted and on the first cycle after it, phase_o is 0, bypass_o is 0 and bit_strobe_o is 0 as long as tx_en is low.
- R2: With std_v21=0 and answer=0, a data bit of 1 (mark) gives 1270 Hz and a bit of 0 (space) gives 1070 Hz. A tone of f Hz steps phase_o each cycle by floor(f * 2^32 / SAMPLE_HZ), taken modulo 2^32.
- R3: With std_v21=0 and answer=1, mark gives 2225 Hz and space gives 2025 Hz.
- R4: With std_v21=1 and answer=0, mark gives 980 Hz and space gives 1180 Hz. The higher tone stands for space.
- R5: With std_v21=1 and answer=1, mark gives 1650 Hz and space gives 1850 Hz.
- R6: bit_strobe_o is high on the first cycle that tx_en is high, and then once every SAMPLE_HZ/BAUD_HZ cycles while tx_en stays high. tx_bit, std_v21 and answer are sampled only on a strobe cycle. Changing them between strobes has no effect on the step.
- R7: On the clock edge that ends a strobe cycle, the accumulator still advances by the old tuning word. From the following edge on, it advances by the new word. The accumulator is never reloaded on a tone change.
- R8: When tx_en goes low, phase_o reads 0 from the next cycle and the accumulator holds its value. After re-enable, phase_o resumes from the held value.
- R9: bypass_o equals tx_en delayed by one clock cycle.
- R10: The accumulator wraps modulo 2^32 with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one cycle per output sample |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| tx_bit | input | 1 | Data bit, 1 = mark, 0 = space |
| std_v21 | input | 1 | 0 = Bell 103 tones, 1 = V.21 tones |
| answer | input | 1 | 0 = calling-side tones, 1 = answering-side tones |
| phase_o | output | PHASE_W (32) | Phase word for the sine stage, 0 while idle |
| bit_strobe_o | output | 1 | High in the cycle where the inputs are sampled |
| bypass_o | output | 1 | Request to skip rate conversion and scrambling |

## Verification
Two events can land in the same cycle: a bit strobe that loads a new tuning word, and an accumulator step that still uses the old word. The bench provokes this by changing the bit, the standard and the role at every strobe. A reference model, clocked at the same edges, predicts the phase word for every sample, so a tuning word applied one edge early or late shows up as a mismatch. A second overlap comes from dropping tx_en in the cycle right after a strobe. The model then predicts one final step followed by a held, zero-masked accumulator, and the resumed phase after re-enable is compared with that prediction.

// File: rtl/fsk_tone_pkg.sv
// Shared helpers for the FSK tone modulator.
// Assumes: the index of a tone is {std_v21, answer, bit}, and bit 1 means mark.
package fsk_tone_pkg;

    localparam int TONE_COUNT = 8;

    // Tone frequency in Hz for a given {standard, role, bit} index.
    function automatic int tone_hz(input int idx);
        case (idx)
            0:       return 1070;  // Bell 103 calling, space
            1:       return 1270;  // Bell 103 calling, mark
            2:       return 2025;  // Bell 103 answering, space
            3:       return 2225;  // Bell 103 answering, mark
            4:       return 1180;  // V.21 calling, space
            5:       return 980;   // V.21 calling, mark
            6:       return 1850;  // V.21 answering, space
            default: return 1650;  // V.21 answering, mark
        endcase
    endfunction

    // Per-sample phase step: floor(hz * 2^pw / fs), computed in 64 bits.
    function automatic longint unsigned tune_word(input int hz, input int fs, input int pw);
        longint unsigned num;
        num = longint'(hz) << pw;
        return num / longint'(fs);
    endfunction

endpackage

// File: rtl/fsk_bit_timer.sv
// Bit-rate strobe generator.
// Raises strobe in the first enabled cycle, then once every SPB cycles.
// Assumes: SPB >= 2; the count returns to zero whenever en is low.
module fsk_bit_timer #(
    parameter int SPB = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic strobe
);
    localparam int CW = (SPB > 2) ? $clog2(SPB) : 1;
    localparam logic [CW-1:0] LAST = CW'(SPB - 1);

    logic [CW-1:0] cnt_q;

    // Strobe whenever enabled and the count sits at zero.
    assign strobe = en && (cnt_q == '0);

    // Count samples within the current bit; clear while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/fsk_tone_table.sv
// Tuning word selector.
// Holds the eight tuning words as constants and latches one on each strobe.
// Assumes: the selects are only meaningful in a strobe cycle.
module fsk_tone_table
    import fsk_tone_pkg::*;
#(
    parameter int PHASE_W   = 32,
    parameter int SAMPLE_HZ = 9600
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               std_v21,
    input  logic               answer,
    input  logic               tx_bit,
    output logic [PHASE_W-1:0] inc
);
    logic [PHASE_W-1:0] words [TONE_COUNT];
    logic [2:0]         sel;

    // Build the constant table, one entry per tone.
    for (genvar g = 0; g < TONE_COUNT; g++) begin : g_word
        assign words[g] = PHASE_W'(tune_word(tone_hz(g), SAMPLE_HZ, PHASE_W));
    end

    // Form the index from standard, role and bit.
    assign sel = {std_v21, answer, tx_bit};

    // Capture the selected word on a strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc <= '0;
        end else if (load) begin
            inc <= words[sel];
        end
    end
endmodule

// File: rtl/fsk_phase_nco.sv
// Phase accumulator.
// Advances by inc each cycle while running; masks its output to zero while idle.
// Assumes: a tone change only alters inc, never the accumulator.
module fsk_phase_nco #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_en,
    input  logic [PHASE_W-1:0] inc,
    output logic [PHASE_W-1:0] acc,
    output logic               run,
    output logic [PHASE_W-1:0] phase
);
    // Register the enable so that the output mask lines up with the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else begin
            run <= tx_en;
        end
    end

    // Step the accumulator modulo 2^PHASE_W while running; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (run) begin
            acc <= acc + inc;
        end
    end

    // Present zero phase while idle.
    assign phase = run ? acc : '0;
endmodule

// File: rtl/fsk_tone_mod.sv
// Dual-standard FSK tone modulator, top level.
// Each clock cycle is one output sample. Selects are taken at the bit strobe.
// Assumes: SAMPLE_HZ is a multiple of BAUD_HZ and SAMPLE_HZ/BAUD_HZ >= 2.
module fsk_tone_mod #(
    parameter int PHASE_W   = 32,
    parameter int SAMPLE_HZ = 9600,
    parameter int BAUD_HZ   = 300
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_en,
    input  logic               tx_bit,
    input  logic               std_v21,
    input  logic               answer,
    output logic [PHASE_W-1:0] phase_o,
    output logic               bit_strobe_o,
    output logic               bypass_o
);
    localparam int SPB = SAMPLE_HZ / BAUD_HZ;

    logic               strobe;
    logic [PHASE_W-1:0] tone_inc;
    logic [PHASE_W-1:0] nco_acc;
    logic               nco_run;

    fsk_bit_timer #(.SPB(SPB)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (tx_en),
        .strobe (strobe)
    );

    fsk_tone_table #(.PHASE_W(PHASE_W), .SAMPLE_HZ(SAMPLE_HZ)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (strobe),
        .std_v21 (std_v21),
        .answer  (answer),
        .tx_bit  (tx_bit),
        .inc     (tone_inc)
    );

    fsk_phase_nco #(.PHASE_W(PHASE_W)) u_nco (
        .clk   (clk),
        .rst_n (rst_n),
        .tx_en (tx_en),
        .inc   (tone_inc),
        .acc   (nco_acc),
        .run   (nco_run),
        .phase (phase_o)
    );

    // The data path bypass follows the transmit state.
    assign bit_strobe_o = strobe;
    assign bypass_o     = nco_run;
endmodule

// File: rtl/fsk_tone_mod_checker.sv
// Property checker for fsk_tone_mod, attached through bind.
module fsk_tone_mod_checker #(
    parameter int PHASE_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tx_en,
    input logic [PHASE_W-1:0] phase_o,
    input logic               bit_strobe_o,
    input logic               bypass_o,
    input logic [PHASE_W-1:0] tone_inc,
    input logic [PHASE_W-1:0] nco_acc,
    input logic               nco_run
);
    // R6: a strobe only occurs while enabled.
    a_r6_strobe_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe_o |-> tx_en);

    // R6: the tuning word moves only after a strobe.
    a_r6_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_strobe_o |=> $stable(tone_inc));

    // R7 and R10: a running accumulator steps by the previous word, modulo 2^W.
    a_r7_continuous_step: assert property (@(posedge clk) disable iff (!rst_n)
        nco_run |=> (nco_acc == $past(nco_acc) + $past(tone_inc)));

    // R8: an idle accumulator holds its value.
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !nco_run |=> $stable(nco_acc));

    // R8: the output reads zero while no bypass is requested.
    a_r8_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass_o |-> (phase_o == '0));

    // R9: bypass follows the enable one cycle later.
    a_r9_bypass_on: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |=> bypass_o);
    a_r9_bypass_off: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !bypass_o);
endmodule

bind fsk_tone_mod fsk_tone_mod_checker #(.PHASE_W(PHASE_W)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_en        (tx_en),
    .phase_o      (phase_o),
    .bit_strobe_o (bit_strobe_o),
    .bypass_o     (bypass_o),
    .tone_inc     (tone_inc),
    .nco_acc      (nco_acc),
    .nco_run      (nco_run)
);

// File: tb/fsk_tone_mod_tb_top.sv
// Scoreboard bench: a clocked model pushes per-sample expectations, and a monitor compares them.
module fsk_tone_mod_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FS         = 9600;
    localparam int SPB        = FS / 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic        tx_bit = 1'b0;
    logic        std_v21 = 1'b0;
    logic        answer = 1'b0;
    logic [31:0] phase_o;
    logic        bit_strobe_o;
    logic        bypass_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] phase;
        logic        byp;
        logic        cnt_zero;
    } exp_t;
    exp_t exp_q[$];

    fsk_tone_mod dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_en        (tx_en),
        .tx_bit       (tx_bit),
        .std_v21      (std_v21),
        .answer       (answer),
        .phase_o      (phase_o),
        .bit_strobe_o (bit_strobe_o),
        .bypass_o     (bypass_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tone table written from R2, R3, R4 and R5.
    function automatic int hz_of(input logic v21, input logic ans, input logic b);
        if (!v21 && !ans) return b ? 1270 : 1070;
        if (!v21 &&  ans) return b ? 2225 : 2025;
        if ( v21 && !ans) return b ? 980  : 1180;
        return b ? 1650 : 1850;
    endfunction

    function automatic logic [31:0] word_of(input int hz);
        longint unsigned t;
        t = (longint'(hz) << 32) / longint'(FS);
        return t[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference model, updated at each clock edge.
    logic [31:0] m_acc = '0, m_inc = '0;
    logic        m_run = 1'b0;
    int          m_cnt = 0;
    always @(posedge clk) begin
        exp_t e;
        if (!rst_n) begin
            m_acc = '0; m_inc = '0; m_run = 1'b0; m_cnt = 0;
        end else begin
            if (m_run) m_acc = m_acc + m_inc;
            if (tx_en && m_cnt == 0) m_inc = word_of(hz_of(std_v21, answer, tx_bit));
            m_run = tx_en;
            m_cnt = !tx_en ? 0 : (m_cnt == SPB-1 ? 0 : m_cnt + 1);
        end
        e.phase = m_run ? m_acc : '0;
        e.byp = m_run;
        e.cnt_zero = (m_cnt == 0);
        exp_q.push_back(e);
    end

    // Monitor: compare each sample halfway through the cycle.
    always @(negedge clk) begin
        if (exp_q.size() > 0 && !done) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.byp ? "R7 phase" : "R8 phase", phase_o, e.phase);
            check("R9 bypass", {31'b0, bypass_o}, {31'b0, e.byp});
            check("R6 strobe", {31'b0, bit_strobe_o}, {31'b0, e.cnt_zero & tx_en});
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Select a tone, wait for its strobe, and measure one step.
    task automatic measure(input string req, input logic v21, input logic ans, input logic b, input int hz);
        logic [31:0] p0;
        std_v21 = v21; answer = ans; tx_bit = b;
        do @(negedge clk); while (!bit_strobe_o);
        repeat (2) @(negedge clk);
        p0 = phase_o;
        @(negedge clk);
        check(req, phase_o - p0, word_of(hz));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] p0;
        step(3);
        @(negedge clk);
        check("R1 phase", phase_o, 32'h0);
        check("R1 bypass", {31'b0, bypass_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 strobe", {31'b0, bit_strobe_o}, 32'h0);
        step(1);
        tx_en = 1'b1;
        measure("R2 mark",  0, 0, 1, 1270);
        measure("R2 space", 0, 0, 0, 1070);
        measure("R3 mark",  0, 1, 1, 2225);
        measure("R3 space", 0, 1, 0, 2025);
        measure("R4 mark",  1, 0, 1, 980);
        measure("R4 space", 1, 0, 0, 1180);
        measure("R5 mark",  1, 1, 1, 1650);
        measure("R5 space", 1, 1, 0, 1850);
        // R6: a change between strobes leaves the step unchanged.
        tx_bit = 1'b1; std_v21 = 1'b0;
        @(negedge clk); p0 = phase_o;
        @(negedge clk);
        check("R6 ignored", phase_o - p0, word_of(1850));
        // R10: the V.21 answering tones wrap the accumulator within the bit.
        // R8: drop the enable in the cycle after a strobe, then resume.
        do @(negedge clk); while (!bit_strobe_o);
        @(posedge clk); #1;
        tx_en = 1'b0;
        step(5);
        @(negedge clk);
        check("R8 idle zero", phase_o, 32'h0);
        step(1);
        tx_en = 1'b1;
        measure("R2 resume", 0, 0, 1, 1270);
        for (int k = 0; k < 6; k++) begin
            std_v21 = k[0]; answer = k[1]; tx_bit = ~k[0];
            step(SPB);
        end
        tx_en = 1'b0;
        step(4);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule